// File: doc/BRIEF.md
# Traffic Signal Sequencer

This block drives the three lamps of a single traffic signal from a slow system clock. A prescaler turns the clock into a fixed step period. A binary step counter advances once per step and wraps from 7 back to 0. The lamps are decoded from the counter bits with plain AND/OR gating and then registered. The resulting cycle has eight steps in four phases: red alone, then red with yellow, then green alone, then yellow with green. After the last phase the cycle starts again at red and repeats without end.

With the default divide ratio of 8 and a 10 Hz clock, one step takes 0.8 s and a full cycle takes 6.4 s. A run enable lets the surrounding logic freeze the sequence where it stands. A synchronous reset starts the sequence again from the beginning of red.

Top module: `traffic_seq`

## Requirements
- R1: While `rst` is high at a clock edge, the lamp outputs become red alone ({red,yel,grn} = 100) and the prescaler and step counter clear. After reset is released, red alone stays lit for 3 full steps.
- R2: One step lasts DIV enabled clocks. The lamps change one clock after the enabled clock that ends a step.
- R3: Steps 0, 1 and 2 light red alone, 3 steps in total.
- R4: Step 3 lights red and yellow together (110) for 1 step.
- R5: Steps 4 and 5 light green alone (001) for 2 steps.
- R6: Steps 6 and 7 light yellow and green together (011) for 2 steps. Red alone follows them, so one full cycle takes 8*DIV enabled clocks.
- R7: A clock with `run_en` low leaves the prescaler and the step counter unchanged. After two or more such clocks in a row, the lamps hold. A lamp change that was already due from the last enabled clock still appears. When `run_en` returns high, the sequence resumes from where it stopped.
- R8: At least one lamp is lit in every cycle, and red and green are never lit together.
- R9: Reset takes priority over a low `run_en`: a reset applied while the sequence is frozen still restarts it at red.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| run_en | input | 1 | Run enable; low freezes the sequence |
| lamp_red | output | 1 | Red lamp, registered |
| lamp_yel | output | 1 | Yellow lamp, registered |
| lamp_grn | output | 1 | Green lamp, registered |

## Verification
Two events can fall in the same cycle: a drop of `run_en` and the prescaler's last count, which would advance the step. The bench waits until its own model stands one clock before a step boundary and lowers the enable exactly there. It also drives a pseudo-random enable pattern, so that pauses land on every prescaler count. A second pairing is reset arriving while the sequence is frozen, which is applied mid-green. In every case the bench judges the result against a reference model that counts enabled clocks since reset. It compares the lamps on every clock.

// File: rtl/tlight_pkg.sv
package tlight_pkg;
   localparam int STEP_W = 3;
   localparam int NUM_STEPS = 1 << STEP_W;

   typedef struct packed {
      logic red;
      logic yel;
      logic grn;
   } lamp_t;

   localparam lamp_t LAMP_AT_RESET = '{red: 1'b1, yel: 1'b0, grn: 1'b0};
endpackage

// File: rtl/tl_prescale.sv
module tl_prescale #(
   parameter int DIV = 8
) (
   input  logic clk,
   input  logic rst,
   input  logic en,
   output logic tick
);
   localparam int W = (DIV > 1) ? $clog2(DIV) : 1;

   generate
      if (DIV < 1) begin : g_bad
         $error("tl_prescale: DIV must be at least 1");
      end
      if (DIV == 1) begin : g_pass
         assign tick = en;
      end else begin : g_cnt
         localparam logic [W-1:0] LAST = W'(DIV - 1);
         logic [W-1:0] cnt;

         always_ff @(posedge clk) begin
            if (rst)
               cnt <= '0;
            else if (en)
               cnt <= (cnt == LAST) ? '0 : cnt + 1'b1;
         end

         assign tick = en && (cnt == LAST);

         // R2
         cnt_range_chk: assert property (@(posedge clk) disable iff (rst)
            cnt <= LAST);

         // R7
         cnt_hold_chk: assert property (@(posedge clk) disable iff (rst)
            !en |=> $stable(cnt));
      end
   endgenerate
endmodule

// File: rtl/tl_stepcnt.sv
module tl_stepcnt
   import tlight_pkg::*;
(
   input  logic              clk,
   input  logic              rst,
   input  logic              adv,
   input  logic              en,
   output logic [STEP_W-1:0] step
);
   always_ff @(posedge clk) begin
      if (rst)
         step <= '0;
      else if (adv)
         step <= step + 1'b1;
   end

   // R2
   step_adv_chk: assert property (@(posedge clk) disable iff (rst)
      !adv |=> $stable(step));

   // R7
   step_hold_chk: assert property (@(posedge clk) disable iff (rst)
      !en |=> $stable(step));
endmodule

// File: rtl/tl_lampdec.sv
module tl_lampdec
   import tlight_pkg::*;
(
   input  logic              clk,
   input  logic              rst,
   input  logic [STEP_W-1:0] step,
   output lamp_t             lamps
);
   logic  q0, q1, q2;
   lamp_t nxt;

   assign q0 = step[0];
   assign q1 = step[1];
   assign q2 = step[2];

   always_comb begin
      nxt.red = ~q2;
      nxt.yel = q1 & (q2 | q0);
      nxt.grn = q2;
   end

   always_ff @(posedge clk) begin
      if (rst)
         lamps <= LAMP_AT_RESET;
      else
         lamps <= nxt;
   end

   // R8
   lamp_lit_chk: assert property (@(posedge clk) disable iff (rst)
      (lamps.red | lamps.yel | lamps.grn) && !(lamps.red && lamps.grn));

   // R5
   grn_after_ry_chk: assert property (@(posedge clk) disable iff (rst)
      $rose(lamps.grn) |-> $past(lamps.red && lamps.yel));

   // R6
   red_after_yg_chk: assert property (@(posedge clk) disable iff (rst)
      $rose(lamps.red) |-> $past(lamps.yel && lamps.grn));
endmodule

// File: rtl/traffic_seq.sv
module traffic_seq
   import tlight_pkg::*;
#(
   parameter int DIV = 8
) (
   input  logic clk,
   input  logic rst,
   input  logic run_en,
   output logic lamp_red,
   output logic lamp_yel,
   output logic lamp_grn
);
   generate
      if (STEP_W != 3) begin : g_bad_w
         $error("traffic_seq: lamp decode assumes a 3-bit step counter");
      end
   endgenerate

   logic              tick;
   logic [STEP_W-1:0] step;
   lamp_t             lamps;

   tl_prescale #(.DIV(DIV)) u_pre (
      .clk  (clk),
      .rst  (rst),
      .en   (run_en),
      .tick (tick)
   );

   tl_stepcnt u_step (
      .clk  (clk),
      .rst  (rst),
      .adv  (tick),
      .en   (run_en),
      .step (step)
   );

   tl_lampdec u_dec (
      .clk   (clk),
      .rst   (rst),
      .step  (step),
      .lamps (lamps)
   );

   assign lamp_red = lamps.red;
   assign lamp_yel = lamps.yel;
   assign lamp_grn = lamps.grn;

   // R7
   frozen_lamps_chk: assert property (@(posedge clk) disable iff (rst)
      (!run_en && !$past(run_en)) |=> $stable({lamp_red, lamp_yel, lamp_grn}));

   // R1
   reset_red_chk: assert property (@(posedge clk)
      rst |=> (lamp_red && !lamp_yel && !lamp_grn));
endmodule

// File: tb/sim_traffic_seq.sv
module sim_traffic_seq;
   localparam int DIV = 8;

   logic clk = 1'b0;
   logic rst = 1'b1;
   logic run_en = 1'b0;
   logic lamp_red, lamp_yel, lamp_grn;

   always #5 clk = ~clk;

   traffic_seq #(.DIV(DIV)) u0 (
      .clk(clk), .rst(rst), .run_en(run_en),
      .lamp_red(lamp_red), .lamp_yel(lamp_yel), .lamp_grn(lamp_grn)
   );

   int compared = 0;
   int mismatched = 0;
   int en_cnt = 0;
   logic [2:0] exp_l = 3'b100;
   logic started = 1'b0;
   logic prev_en = 1'b1;
   logic prev_rst = 1'b0;
   int cyc = 0;
   int last_ry = -1;
   logic prev_ry = 1'b0;
   logic measure = 1'b0;
   logic done = 1'b0;

   function automatic logic [2:0] phase_of(int s);
      case (s)
         0, 1, 2: return 3'b100;
         3:       return 3'b110;
         4, 5:    return 3'b001;
         default: return 3'b011;
      endcase
   endfunction

   function automatic string tag_of(logic [2:0] e);
      case (e)
         3'b100:  return "R3";
         3'b110:  return "R4";
         3'b001:  return "R5";
         default: return "R6";
      endcase
   endfunction

   // reference model: counts enabled clocks since reset
   always @(posedge clk) begin
      if (rst) begin
         en_cnt <= 0;
         exp_l  <= 3'b100;
      end else begin
         exp_l <= phase_of((en_cnt / DIV) % 8);
         if (run_en) en_cnt <= en_cnt + 1;
      end
      prev_en  <= run_en;
      prev_rst <= rst;
      cyc      <= cyc + 1;
   end

   always @(negedge clk) begin
      if (rst) started = 1'b1;
      if (started && !done) begin
         logic [2:0] act;
         string t;
         act = {lamp_red, lamp_yel, lamp_grn};
         t = tag_of(exp_l);
         if (prev_rst) t = (prev_en) ? "R1" : "R9";
         else if (!prev_en) t = "R7";
         else if (en_cnt < 3 * DIV) t = "R1";
         if (act == 3'b000 || (act[2] && act[0])) t = "R8";
         compared++;
         if (act !== exp_l) begin
            mismatched++;
            $display("FAIL %s cycle %0d: lamps actual %b expected %b", t, cyc, act, exp_l);
         end
         // R6 / R2: full cycle length between red+yellow onsets
         if (measure && act == 3'b110 && !prev_ry) begin
            if (last_ry >= 0) begin
               compared++;
               if (cyc - last_ry != 8 * DIV) begin
                  mismatched++;
                  $display("FAIL R6 cycle length actual %0d expected %0d", cyc - last_ry, 8 * DIV);
               end
            end
            last_ry = cyc;
         end
         prev_ry = (act == 3'b110);
      end
   end

   task automatic cycles(int n);
      for (int i = 0; i < n; i++) @(negedge clk);
   endtask

   initial begin
      // R1: reset state
      rst = 1'b1; run_en = 1'b1;
      cycles(3);
      rst = 1'b0;
      // R3 R4 R5 R6: three uninterrupted cycles with period measurement
      measure = 1'b1;
      cycles(24 * DIV);
      measure = 1'b0;
      // R7: drop enable exactly on the last prescaler count of a step
      for (int k = 0; k < 6; k++) begin
         while ((en_cnt % DIV) != DIV - 1) @(negedge clk);
         run_en = 1'b0;
         cycles(3 + k);
         run_en = 1'b1;
         cycles(k + 1);
      end
      // R7: pseudo-random enable pattern
      begin
         logic [7:0] lf;
         lf = 8'hA5;
         for (int i = 0; i < 600; i++) begin
            lf = {lf[6:0], lf[7] ^ lf[5] ^ lf[4] ^ lf[3]};
            run_en = (lf[1:0] != 2'b00);
            @(negedge clk);
         end
      end
      run_en = 1'b1;
      // R9: reset while frozen mid-green
      while (exp_l != 3'b001) @(negedge clk);
      run_en = 1'b0;
      cycles(2);
      rst = 1'b1;
      cycles(2);
      rst = 1'b0;
      cycles(4);
      run_en = 1'b1;
      // R1: red alone lasts three full steps after release
      cycles(10 * DIV);
      // reset mid-sequence with enable high
      rst = 1'b1;
      cycles(1);
      rst = 1'b0;
      cycles(16 * DIV);
      done = 1'b1;
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
   end

   initial begin
      #(200000 * 10);
      done = 1'b1;
      mismatched++;
      $display("FAIL watchdog: run did not finish, actual timeout expected completion");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
   end
endmodule